// File: doc/BRIEF.md
# NAND Flash Sequential Page-Read Pointer

This block is the read side of a byte-wide NAND flash device. It watches the host strobes (chip enable, command latch enable, address latch enable, write strobe, read strobe), all active as in a normal NAND bus and all sampled on the device clock. A read command picks the region where reading starts: the lower half-page (columns 0–255), the upper half-page (columns 256–511) or the 16-byte spare area (columns 512–527). One column byte and two row bytes then give the start position. When the last address byte is latched, the page is copied from the array into an on-chip 528-byte data register. While the copy runs, the ready/busy output is low. Each read strobe after that puts one byte on the output bus and advances the column. Reading past column 527 loads the next page by itself, and the column restarts at the start of the region that was chosen.

The controller is a four-state machine. IDLE means no read is set up. ADDR collects the address bytes. LOAD means a page copy is running and the device is busy. READ serves bytes. The transitions are:
- IDLE→ADDR and READ→ADDR on a read command.
- Any state→ADDR on a read command, and any state→IDLE on any other command.
- ADDR→LOAD on the third address byte.
- LOAD→READ when the last byte of the page is acknowledged.
- READ→LOAD on the strobe that finishes column 527.
- LOAD→ADDR or LOAD→IDLE on a new command, which also aborts the copy.

A page loader fills the data register. It asks the array for one byte at a time over a request/acknowledge port.

Top module: `nand_rd_ptr`

## Requirements
- R1: After reset, `rdy` is 1, `io_oe` is 0 and `ld_req` is 0.
- R2: Command 00h sets the start column to the column byte (0–255). The address bytes come in a fixed order: the column byte, then the row low byte, then the row high byte. The row is {high,low} truncated to ROW_BITS. The page copy starts when the row high byte is latched.
- R3: Command 01h sets the start column to 256 plus the column byte.
- R4: Command 50h sets the start column to 512 plus bits 3..0 of the column byte. Bits 7..4 of the column byte are ignored.
- R5: In READ, `io_out` shows the data-register byte at the current column. Each rising edge of `re_n` with `ce_n` low advances the column by one. A read strobe while `ce_n` is high has no effect.
- R6: The strobe that finishes column 527 starts a copy of the next row without a new command. The column restarts at 0 after 00h or 01h, and at 512 after 50h.
- R7: The next row after the last page (2^ROW_BITS−1) is page 0.
- R8: `rdy` is 0 from the edge that starts a copy until the edge that takes the last acknowledged byte. Read strobes during that time do not move the column.
- R9: `io_oe` is 1 only in READ, with `ce_n` low and `re_n` low.
- R10: A command latched at any time aborts a running copy or read and restarts the address count. A command other than 00h, 01h or 50h leaves the block in IDLE, where the output is never driven.
- R11: During a copy, `ld_req` stays high. `ld_row` holds the page. `ld_col` steps 0,1,…,527 and advances only on a cycle with `ld_ack` high, which carries that byte on `ld_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe; latches on rising edge |
| re_n | input | 1 | Read strobe; byte out while low, advance on rising edge |
| io_in | input | 8 | Command/address byte from host |
| io_out | output | 8 | Data byte to host |
| io_oe | output | 1 | Output enable for the I/O bus |
| rdy | output | 1 | Ready (1) / busy (0) |
| ld_req | output | 1 | Array byte request |
| ld_row | output | ROW_BITS | Page being copied |
| ld_col | output | 10 | Column being requested |
| ld_ack | input | 1 | Array returns requested byte |
| ld_data | input | 8 | Byte from the array |

## Verification
The bench builds the block with ROW_BITS = 4, which gives 16 pages. With so few pages, the wrap from the last page to page 0 (R7) is reached after only a few page copies. The half-page and spare sizes keep their default values, so the real column boundaries at 256, 512 and 527 are exercised. The array model in the bench holds back the acknowledge on every third cycle, so the stall behaviour of R11 and the exact length of the busy period are checked on every page copy.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
    typedef enum logic [1:0] {S_IDLE, S_ADDR, S_LOAD, S_READ} rd_state_t;
    typedef enum logic [1:0] {M_LOW, M_HIGH, M_SPARE} rd_mode_t;
    localparam logic [7:0] CMD_LOW   = 8'h00;
    localparam logic [7:0] CMD_HIGH  = 8'h01;
    localparam logic [7:0] CMD_SPARE = 8'h50;
    typedef enum logic {L_IDLE, L_FILL} ld_state_t;
endpackage

// File: rtl/nand_strobe_edge.sv
module nand_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sig;
    end

    assign rise = sig & ~prev_q;
endmodule

// File: rtl/nand_page_loader.sv
module nand_page_loader
    import nand_rd_pkg::*;
#(
    parameter int PAGE_BYTES = 528,
    parameter int ROW_BITS   = 14,
    parameter int COL_W      = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                abort,
    input  logic [ROW_BITS-1:0] start_row,
    output logic                ld_req,
    output logic [ROW_BITS-1:0] ld_row,
    output logic [COL_W-1:0]    ld_col,
    input  logic                ld_ack,
    input  logic [7:0]          ld_data,
    output logic                done,
    input  logic [COL_W-1:0]    rd_col,
    output logic [7:0]          rd_data
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

    ld_state_t         st_q;
    logic [COL_W-1:0]  cnt_q;
    logic [ROW_BITS-1:0] row_q;
    logic [7:0]        page_mem [PAGE_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= L_IDLE;
            cnt_q <= '0;
            row_q <= '0;
        end else begin
            unique case (st_q)
                L_IDLE: if (start) begin
                    st_q  <= L_FILL;
                    cnt_q <= '0;
                    row_q <= start_row;
                end
                L_FILL: if (abort) begin
                    st_q <= L_IDLE;
                end else if (ld_ack) begin
                    if (cnt_q == LAST_COL) st_q <= L_IDLE;
                    else                   cnt_q <= cnt_q + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (st_q == L_FILL && ld_ack && !abort) page_mem[cnt_q] <= ld_data;
    end

    always_comb begin
        ld_req  = (st_q == L_FILL);
        ld_row  = row_q;
        ld_col  = cnt_q;
        done    = (st_q == L_FILL) && ld_ack && !abort && (cnt_q == LAST_COL);
        rd_data = page_mem[rd_col];
    end

    // R11: a stalled request holds its column
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !ld_ack && !abort) |=> $stable(ld_col));
    // R11: an acknowledged byte moves the column on by one
    p_ack_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && ld_ack && !abort && ld_col != LAST_COL) |=> (ld_col == $past(ld_col) + 1'b1));
endmodule

// File: rtl/nand_rd_ptr.sv
module nand_rd_ptr
    import nand_rd_pkg::*;
#(
    parameter int HALF_BYTES  = 256,
    parameter int SPARE_BYTES = 16,
    parameter int ROW_BITS    = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_n,
    input  logic                 cle,
    input  logic                 ale,
    input  logic                 we_n,
    input  logic                 re_n,
    input  logic [7:0]           io_in,
    output logic [7:0]           io_out,
    output logic                 io_oe,
    output logic                 rdy,
    output logic                 ld_req,
    output logic [ROW_BITS-1:0]  ld_row,
    output logic [$clog2(2*HALF_BYTES+SPARE_BYTES)-1:0] ld_col,
    input  logic                 ld_ack,
    input  logic [7:0]           ld_data
);
    localparam int PAGE_BYTES = 2 * HALF_BYTES + SPARE_BYTES;
    localparam int COL_W      = $clog2(PAGE_BYTES);
    localparam int SP_W       = $clog2(SPARE_BYTES);
    localparam logic [COL_W-1:0] LAST_COL   = COL_W'(PAGE_BYTES - 1);
    localparam logic [COL_W-1:0] HALF_BASE  = COL_W'(HALF_BYTES);
    localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(2 * HALF_BYTES);

    rd_state_t           state_q, state_d;
    rd_mode_t            mode_q;
    logic [1:0]          adr_idx_q;
    logic [COL_W-1:0]    col_q;
    logic [ROW_BITS-1:0] row_q, row_next;
    logic [7:0]          row_lo_q;
    logic                we_rise, re_rise;
    logic                cmd_hit, adr_hit, rd_step, is_read_cmd;
    logic                ld_start, ld_abort, ld_done;
    logic [COL_W-1:0]    start_col, restart_col;
    logic [7:0]          rd_data;

    nand_strobe_edge u_we_edge (.clk(clk), .rst_n(rst_n), .sig(we_n), .rise(we_rise));
    nand_strobe_edge u_re_edge (.clk(clk), .rst_n(rst_n), .sig(re_n), .rise(re_rise));

    nand_page_loader #(
        .PAGE_BYTES(PAGE_BYTES), .ROW_BITS(ROW_BITS), .COL_W(COL_W)
    ) u_loader (
        .clk(clk), .rst_n(rst_n), .start(ld_start), .abort(ld_abort),
        .start_row(row_next), .ld_req(ld_req), .ld_row(ld_row), .ld_col(ld_col),
        .ld_ack(ld_ack), .ld_data(ld_data), .done(ld_done),
        .rd_col(col_q), .rd_data(rd_data)
    );

    // strobe decode and column/row arithmetic
    always_comb begin
        cmd_hit     = we_rise && !ce_n && cle && !ale;
        adr_hit     = we_rise && !ce_n && ale && !cle;
        rd_step     = re_rise && !ce_n && (state_q == S_READ);
        is_read_cmd = (io_in == CMD_LOW) || (io_in == CMD_HIGH) || (io_in == CMD_SPARE);
        unique case (mode_q)
            M_HIGH:  start_col = HALF_BASE + COL_W'(io_in);
            M_SPARE: start_col = SPARE_BASE + COL_W'(io_in[SP_W-1:0]);
            default: start_col = COL_W'(io_in);
        endcase
        restart_col = (mode_q == M_SPARE) ? SPARE_BASE : '0;
        row_next    = (state_q == S_ADDR) ? ROW_BITS'({io_in, row_lo_q}) : row_q + 1'b1;
    end

    // next state
    always_comb begin
        state_d  = state_q;
        ld_start = 1'b0;
        ld_abort = 1'b0;
        if (cmd_hit) begin
            ld_abort = (state_q == S_LOAD);
            state_d  = is_read_cmd ? S_ADDR : S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_ADDR: if (adr_hit && adr_idx_q == 2'd2) begin
                    state_d  = S_LOAD;
                    ld_start = 1'b1;
                end
                S_LOAD: if (ld_done) state_d = S_READ;
                S_READ: if (rd_step && col_q == LAST_COL) begin
                    state_d  = S_LOAD;
                    ld_start = 1'b1;
                end
            endcase
        end
    end

    // state register and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            mode_q    <= M_LOW;
            adr_idx_q <= '0;
            col_q     <= '0;
            row_q     <= '0;
            row_lo_q  <= '0;
        end else begin
            state_q <= state_d;
            if (cmd_hit) begin
                adr_idx_q <= '0;
                if (io_in == CMD_HIGH)       mode_q <= M_HIGH;
                else if (io_in == CMD_SPARE) mode_q <= M_SPARE;
                else if (io_in == CMD_LOW)   mode_q <= M_LOW;
            end else if (state_q == S_ADDR && adr_hit) begin
                adr_idx_q <= adr_idx_q + 1'b1;
                case (adr_idx_q)
                    2'd0:    col_q    <= start_col;
                    2'd1:    row_lo_q <= io_in;
                    default: ;
                endcase
            end else if (rd_step) begin
                col_q <= (col_q == LAST_COL) ? restart_col : col_q + 1'b1;
            end
            if (ld_start) row_q <= row_next;
        end
    end

    // outputs
    always_comb begin
        rdy    = (state_q != S_LOAD);
        io_oe  = (state_q == S_READ) && !ce_n && !re_n;
        io_out = rd_data;
    end

    // R9: the bus is never driven while busy
    p_oe_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> rdy);
    // R5: the column pointer stays inside the page
    p_col_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        col_q <= LAST_COL);
    // R8: read strobes while busy leave the column alone
    p_busy_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOAD) |=> $stable(col_q));
    // R4: spare mode keeps the pointer in the spare columns
    p_spare_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_SPARE && (state_q == S_LOAD || state_q == S_READ)) |-> (col_q >= SPARE_BASE));
endmodule

// File: tb/nand_rd_ptr_tb.sv
module nand_rd_ptr_tb_top;
    localparam int ROWB  = 4;
    localparam int PAGES = 1 << ROWB;
    localparam int PAGE  = 528;
    localparam int LAST  = 527;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic [7:0] io_in = '0;
    logic [7:0] io_out;
    logic io_oe, rdy, ld_req;
    logic [ROWB-1:0] ld_row;
    logic [9:0] ld_col;
    logic ld_ack = 1'b0;
    logic [7:0] ld_data = '0;

    int tests = 0, fails = 0, cyc = 0;

    always #5 clk = ~clk;

    nand_rd_ptr #(.ROW_BITS(ROWB)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rdy(rdy),
        .ld_req(ld_req), .ld_row(ld_row), .ld_col(ld_col), .ld_ack(ld_ack), .ld_data(ld_data)
    );

    function automatic logic [7:0] pat(int row, int col);
        return 8'((row * 37 + col * 5 + (col >> 8)) ^ 8'h5A);
    endfunction

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // array model with a stall on every third cycle
    always @(negedge clk) begin
        cyc++;
        ld_ack  = ld_req && (cyc % 3 != 2);
        ld_data = pat(int'(ld_row), int'(ld_col));
    end

    // behavioural reference model (0 idle, 1 addr, 2 load, 3 read)
    int m_state, m_mode, m_idx, m_col, m_row, m_lo, m_acks;
    bit m_pwe, m_pre;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_mode = 0; m_idx = 0; m_col = 0; m_row = 0; m_lo = 0; m_acks = 0;
            m_pwe = 1; m_pre = 1;
        end else begin
            bit wr, rr, cmd, adr;
            wr = we_n && !m_pwe;  rr = re_n && !m_pre;
            m_pwe = we_n;  m_pre = re_n;
            cmd = wr && !ce_n && cle && !ale;
            adr = wr && !ce_n && ale && !cle;
            if (cmd) begin
                m_idx = 0;
                if (io_in == 8'h00 || io_in == 8'h01 || io_in == 8'h50) begin
                    m_mode = (io_in == 8'h00) ? 0 : (io_in == 8'h01) ? 1 : 2;
                    m_state = 1;
                end else m_state = 0;
            end else if (m_state == 1) begin
                if (adr) begin
                    if (m_idx == 0)
                        m_col = (m_mode == 0) ? io_in : (m_mode == 1) ? 256 + io_in : 512 + (io_in & 15);
                    else if (m_idx == 1) m_lo = io_in;
                    else begin m_row = (io_in * 256 + m_lo) % PAGES; m_state = 2; m_acks = 0; end
                    m_idx++;
                end
            end else if (m_state == 2) begin
                if (ld_ack) begin m_acks++; if (m_acks == PAGE) m_state = 3; end
            end else if (m_state == 3) begin
                if (rr && !ce_n) begin
                    if (m_col == LAST) begin
                        m_col = (m_mode == 2) ? 512 : 0;
                        m_row = (m_row + 1) % PAGES;
                        m_state = 2; m_acks = 0;
                    end else m_col++;
                end
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 rdy", rdy, m_state != 2);
            chk("R9 io_oe", io_oe, (m_state == 3) && !ce_n && !re_n);
            chk("R11 ld_req", ld_req, m_state == 2);
            if (io_oe) chk("R5 io_out", io_out, pat(m_row, m_col));
            if (ld_req) begin
                chk("R11 ld_col", ld_col, m_acks);
                chk("R7 ld_row", ld_row, m_row);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_byte(logic c, logic a, logic [7:0] b);
        cle = c; ale = a; io_in = b; we_n = 1'b0;
        tick(2);
        we_n = 1'b1;
        tick(2);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        re_n = 1'b0;
        @(negedge clk);
        b = io_out;
        tick(1);
        re_n = 1'b1;
        tick(1);
    endtask

    task automatic wait_rdy();
        while (!rdy) tick(1);
    endtask

    task automatic setup(logic [7:0] cmd, logic [7:0] c, logic [7:0] lo, logic [7:0] hi);
        wr_byte(1'b1, 1'b0, cmd);
        wr_byte(1'b0, 1'b1, c);
        wr_byte(1'b0, 1'b1, lo);
        wr_byte(1'b0, 1'b1, hi);
    endtask

    initial begin
        #200000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        tick(4);
        chk("R1 rdy", rdy, 1);
        chk("R1 io_oe", io_oe, 0);
        chk("R1 ld_req", ld_req, 0);
        rst_n = 1'b1;
        ce_n = 1'b0;
        tick(2);

        // R2: 00h, column 5, row 3
        setup(8'h00, 8'h05, 8'h03, 8'h00);
        chk("R2 busy after last address", rdy, 0);
        wait_rdy();
        rd_byte(b); chk("R2 first byte", b, pat(3, 5));
        rd_byte(b); chk("R5 second byte", b, pat(3, 6));
        // R5: strobe with ce_n high ignored
        ce_n = 1'b1; re_n = 1'b0; tick(2); re_n = 1'b1; tick(2); ce_n = 1'b0;
        rd_byte(b); chk("R5 ce_n high strobe ignored", b, pat(3, 7));

        // R8: strobes while busy do not move the column
        setup(8'h00, 8'h10, 8'h02, 8'h00);
        repeat (3) begin re_n = 1'b0; tick(2); re_n = 1'b1; tick(2); end
        chk("R8 still busy", rdy, 0);
        wait_rdy();
        rd_byte(b); chk("R8 column unmoved", b, pat(2, 16));

        // R3 + row mask, then crossing from 527 (R6)
        setup(8'h01, 8'hFE, 8'h07, 8'hF0);
        wait_rdy();
        rd_byte(b); chk("R3 start 510", b, pat(7, 510));
        for (int i = 511; i <= LAST; i++) begin
            rd_byte(b); chk("R5 run to 527", b, pat(7, i));
        end
        chk("R6 auto load busy", rdy, 0);
        wait_rdy();
        rd_byte(b); chk("R6 restart at col 0 next row", b, pat(8, 0));

        // R4: spare area, upper column bits ignored; wrap of last page (R7)
        setup(8'h50, 8'hAC, 8'h0F, 8'h00);
        wait_rdy();
        for (int i = 524; i <= LAST; i++) begin
            rd_byte(b); chk("R4 spare bytes", b, pat(15, i));
        end
        wait_rdy();
        rd_byte(b); chk("R7 wrap to page 0 col 512", b, pat(0, 512));

        // R10: abort a running copy with a new command
        setup(8'h00, 8'h00, 8'h01, 8'h00);
        tick(20);
        chk("R10 busy before abort", rdy, 0);
        wr_byte(1'b1, 1'b0, 8'h50);
        chk("R10 abort frees rdy", rdy, 1);
        chk("R10 abort drops ld_req", ld_req, 0);
        wr_byte(1'b0, 1'b1, 8'h03);
        wr_byte(1'b0, 1'b1, 8'h04);
        wr_byte(1'b0, 1'b1, 8'h00);
        wait_rdy();
        rd_byte(b); chk("R10 address count restarted", b, pat(4, 515));
        wr_byte(1'b1, 1'b0, 8'hFF);
        re_n = 1'b0; tick(2);
        chk("R10 unknown command idle", io_oe, 0);
        re_n = 1'b1; tick(2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule